// File: doc/BRIEF.md
# Block-Erase Flash Array Model

This block is a synthesizable behavioural model of a non-volatile array that behaves like flash storage. It takes one request per cycle on a small request interface: a read, a byte program, or an erase of a whole block. Reads work like a RAM. The data comes back one cycle after the request.

A program can only move bits from 1 to 0. The stored byte becomes the AND of its old value and the written data. The only way to bring a bit back to 1 is to erase the whole block that holds it. An erase sets every byte of that block to all ones.

Program and erase each hold a busy flag for a fixed number of cycles. The erase time is much longer than the program time. No request of any kind is accepted while busy is high. System models use this block to exercise firmware paths that must erase before they rewrite and must wait out busy periods.

Top module: `flash_model`

## Requirements
- R1: After reset, busy and rd_valid are low, and every location reads as all ones.
- R2: A read (req_op 2'b00) accepted while busy is low raises rd_valid in the next cycle. In that same cycle rd_data holds the stored byte at req_addr.
- R3: A program (req_op 2'b01) accepted while busy is low changes the addressed byte to the AND of its old value and req_wdata. Programming an already-programmed byte therefore never sets a bit.
- R4: An erase (req_op 2'b10) sets every byte of one block to all ones. The block is selected by the upper address bits, req_addr[ADDR_W-1:log2(BLOCK_SIZE)]. Bytes in every other block keep their values.
- R5: After an accepted program, busy is high for exactly PROG_CYCLES cycles, starting in the cycle after acceptance.
- R6: After an accepted erase, busy is high for exactly ERASE_CYCLES cycles, starting in the cycle after acceptance. ERASE_CYCLES must be greater than PROG_CYCLES.
- R7: A request presented while busy is high is refused. A refused program or erase changes no byte and does not extend busy. A refused read produces no rd_valid.
- R8: The reserved operation (req_op 2'b11) is ignored. It raises neither busy nor rd_valid and changes no byte.
- R9: An erase ignores the offset bits of req_addr. Any address inside a block erases that same block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; returns the array to the erased state |
| req_valid | input | 1 | A request is present this cycle |
| req_op | input | 2 | 00 read, 01 program, 10 block erase, 11 reserved |
| req_addr | input | ADDR_W | Byte address; upper bits select the block |
| req_wdata | input | DATA_W | Data to program (AND-ed into the stored byte) |
| busy | output | 1 | Program or erase in progress; requests are refused |
| rd_valid | output | 1 | rd_data holds the result of the read accepted last cycle |
| rd_data | output | DATA_W | Read data |

## Verification
A fault in the array shows up at the first read of an affected byte. That read may return a bit set that a program should have cleared, or a stale byte after an erase. It may also return a changed byte in a block that was not selected. The bench therefore sweeps whole blocks after each directed erase and compares every random read with a shadow copy. A fault in the busy counter shows up in the cycle busy falls, because its high time is measured against the exact expected length. A fault in the acceptance logic shows up in the following cycle as a missing or extra rd_valid, or as a write made during a busy period that a later read exposes.

// File: rtl/flash_pkg.sv
package flash_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'b00,
      OP_PROG  = 2'b01,
      OP_ERASE = 2'b10,
      OP_RSVD  = 2'b11
   } flash_op_e;
endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer #(
   parameter int PROG_CYCLES  = 3,
   parameter int ERASE_CYCLES = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_prog,
   input  logic start_erase,
   output logic busy
);
   localparam int CNT_W = $clog2(ERASE_CYCLES + 1);
   localparam logic [CNT_W-1:0] PROG_LOAD  = CNT_W'(PROG_CYCLES);
   localparam logic [CNT_W-1:0] ERASE_LOAD = CNT_W'(ERASE_CYCLES);

   logic [CNT_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remain_q <= '0;
      else if (start_erase)
         remain_q <= ERASE_LOAD;
      else if (start_prog)
         remain_q <= PROG_LOAD;
      else if (remain_q != '0)
         remain_q <= remain_q - 1'b1;
   end

   assign busy = (remain_q != '0);
endmodule

// File: rtl/flash_cell_array.sv
module flash_cell_array #(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 8,
   parameter int BLOCK_SIZE = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic              prog_en,
   input  logic              erase_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH      = 1 << ADDR_W;
   localparam int OFS_W      = $clog2(BLOCK_SIZE);
   localparam int BLK_W      = ADDR_W - OFS_W;
   localparam int NUM_BLOCKS = 1 << BLK_W;

   logic [DATA_W-1:0]     cells [DEPTH];
   logic [NUM_BLOCKS-1:0] blk_hit;
   logic [BLK_W-1:0]      addr_blk;

   assign addr_blk = addr[ADDR_W-1:OFS_W];

   for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk_dec
      assign blk_hit[b] = erase_en && (addr_blk == BLK_W'(b));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++)
            cells[i] <= '1;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (blk_hit[i / BLOCK_SIZE])
               cells[i] <= '1;
            else if (prog_en && (addr == ADDR_W'(i)))
               cells[i] <= cells[i] & wdata;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_en;
         if (rd_en)
            rd_data <= cells[addr];
      end
   end
endmodule

// File: rtl/flash_model.sv
module flash_model #(
   parameter int ADDR_W       = 8,
   parameter int DATA_W       = 8,
   parameter int BLOCK_SIZE   = 32,
   parameter int PROG_CYCLES  = 3,
   parameter int ERASE_CYCLES = 250
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   import flash_pkg::*;

   localparam int DEPTH = 1 << ADDR_W;

   if ((BLOCK_SIZE < 2) || ((BLOCK_SIZE & (BLOCK_SIZE - 1)) != 0)) begin : g_bad_block
      $error("BLOCK_SIZE must be a power of two of at least 2");
   end
   if (BLOCK_SIZE >= DEPTH) begin : g_bad_depth
      $error("BLOCK_SIZE must be smaller than the array depth");
   end
   if ((PROG_CYCLES < 1) || (ERASE_CYCLES <= PROG_CYCLES)) begin : g_bad_time
      $error("need 1 <= PROG_CYCLES < ERASE_CYCLES");
   end

   flash_op_e op;
   logic      accept;
   logic      do_read;
   logic      do_prog;
   logic      do_erase;

   assign op       = flash_op_e'(req_op);
   assign accept   = req_valid && !busy;
   assign do_read  = accept && (op == OP_READ);
   assign do_prog  = accept && (op == OP_PROG);
   assign do_erase = accept && (op == OP_ERASE);

   flash_busy_timer #(
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_CYCLES(ERASE_CYCLES)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_prog (do_prog),
      .start_erase(do_erase),
      .busy       (busy)
   );

   flash_cell_array #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .BLOCK_SIZE(BLOCK_SIZE)
   ) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (do_read),
      .prog_en (do_prog),
      .erase_en(do_erase),
      .addr    (req_addr),
      .wdata   (req_wdata),
      .rd_valid(rd_valid),
      .rd_data (rd_data)
   );
endmodule

// File: rtl/flash_model_chk.sv
module flash_model_chk #(
   parameter int PROG_CYCLES  = 3,
   parameter int ERASE_CYCLES = 250
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic [1:0] req_op,
   input logic       busy,
   input logic       rd_valid
);
   localparam int CW = $clog2(ERASE_CYCLES + 2);

   logic          take;
   logic [CW-1:0] run_q;
   logic [CW-1:0] want_q;

   assign take = req_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= '0;
         want_q <= '0;
      end else if (take && (req_op == 2'b01)) begin
         run_q  <= '0;
         want_q <= CW'(PROG_CYCLES);
      end else if (take && (req_op == 2'b10)) begin
         run_q  <= '0;
         want_q <= CW'(ERASE_CYCLES);
      end else if (busy) begin
         run_q  <= run_q + 1'b1;
      end
   end

   // R5 R6
   busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == want_q));

   // R5
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && (req_op == 2'b01 || req_op == 2'b10)) |=> busy);

   // R2
   read_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_op == 2'b00) |=> rd_valid);

   // R7
   refused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy || !req_valid) |=> !rd_valid);

   // R8
   rsvd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && req_op == 2'b11) |=> (!busy && !rd_valid));
endmodule

bind flash_model flash_model_chk #(
   .PROG_CYCLES (PROG_CYCLES),
   .ERASE_CYCLES(ERASE_CYCLES)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .req_op   (req_op),
   .busy     (busy),
   .rd_valid (rd_valid)
);

// File: tb/tb_flash_model.sv
module tb_flash_model;
   localparam int CLK_PERIOD = 10;
   localparam int AW  = 8;
   localparam int DW  = 8;
   localparam int BS  = 32;
   localparam int PC  = 3;
   localparam int EC  = 250;
   localparam int DEP = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_op = 2'b00;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          busy;
   logic          rd_valid;
   logic [DW-1:0] rd_data;

   logic [DW-1:0] shadow [DEP];
   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   flash_model #(
      .ADDR_W(AW), .DATA_W(DW), .BLOCK_SIZE(BS),
      .PROG_CYCLES(PC), .ERASE_CYCLES(EC)
   ) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
      .rd_valid(rd_valid), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] prog_result(input logic [DW-1:0] old_v,
                                                 input logic [DW-1:0] d);
      return old_v & d;
   endfunction

   function automatic logic [AW-1:0] blk_base(input logic [AW-1:0] a);
      return a & ~AW'(BS - 1);
   endfunction

   task automatic count_busy(output int n);
      n = 0;
      while (busy === 1'b1) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic do_op(input logic [1:0] op, input logic [AW-1:0] a,
                        input logic [DW-1:0] d);
      int n;
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0;
      case (op)
         2'b00: begin
            chk("R2 rd_valid", int'(rd_valid), 1);
            chk("R2 R3 R4 rd_data", int'(rd_data), int'(shadow[a]));
         end
         2'b01: begin
            shadow[a] = prog_result(shadow[a], d);
            count_busy(n);
            chk("R5 program busy length", n, PC);
         end
         2'b10: begin
            for (int k = 0; k < BS; k++) shadow[blk_base(a) + AW'(k)] = '1;
            count_busy(n);
            chk("R6 erase busy length", n, EC);
         end
         default: begin
            chk("R8 busy after reserved", int'(busy), 0);
            chk("R8 rd_valid after reserved", int'(rd_valid), 0);
         end
      endcase
   endtask

   task automatic summary;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int n;
      int unused_seed;
      unused_seed = $urandom(32'd4242);
      for (int i = 0; i < DEP; i++) shadow[i] = '1;
      repeat (3) @(negedge clk);
      chk("R1 busy in reset", int'(busy), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 rd_valid after reset", int'(rd_valid), 0);
      for (int i = 0; i < DEP; i++) do_op(2'b00, AW'(i), '0);   // R1 all ones

      // R3: program over a programmed byte gives the AND
      do_op(2'b01, 8'h05, 8'hF0);
      do_op(2'b00, 8'h05, '0);
      chk("R3 first program", int'(rd_data), 8'hF0);
      do_op(2'b01, 8'h05, 8'h3C);
      do_op(2'b00, 8'h05, '0);
      chk("R3 AND of old and new", int'(rd_data), 8'h30);

      // R4 R9: erase via non-zero offset, neighbour block untouched
      do_op(2'b01, 8'h41, 8'h12);
      do_op(2'b01, 8'h5F, 8'h00);
      do_op(2'b01, 8'h60, 8'h55);
      do_op(2'b10, 8'h57, '0);
      for (int k = 8'h40; k < 8'h60; k++) do_op(2'b00, AW'(k), '0);
      do_op(2'b00, 8'h60, '0);
      chk("R4 neighbour block kept", int'(rd_data), 8'h55);
      do_op(2'b00, 8'h5F, '0);
      chk("R4 R9 erased byte all ones", int'(rd_data), 8'hFF);

      // R7: requests during an erase are refused
      @(negedge clk);
      req_valid = 1'b1; req_op = 2'b10; req_addr = 8'h45;
      @(negedge clk);
      chk("R7 busy after erase accept", int'(busy), 1);
      req_op = 2'b01; req_addr = 8'h46; req_wdata = 8'h00;
      @(negedge clk);
      chk("R7 no rd_valid for refused program", int'(rd_valid), 0);
      req_op = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R7 no rd_valid for refused read", int'(rd_valid), 0);
      count_busy(n);
      chk("R7 busy not extended", n + 2, EC);
      for (int k = 0; k < BS; k++) shadow[8'h40 + k] = '1;
      do_op(2'b00, 8'h46, '0);
      chk("R7 refused program left byte", int'(rd_data), 8'hFF);

      // R8: reserved op changes nothing
      do_op(2'b11, 8'h05, 8'h00);
      do_op(2'b00, 8'h05, '0);
      chk("R8 byte unchanged", int'(rd_data), 8'h30);

      // Random mix, concentrated on three blocks
      for (int t = 0; t < 400; t++) begin
         int r;
         logic [AW-1:0] a;
         r = int'($urandom_range(99));
         a = {AW'($urandom_range(2)) << $clog2(BS)} | AW'($urandom_range(BS - 1));
         if (r < 45)      do_op(2'b00, a, '0);
         else if (r < 88) do_op(2'b01, a, DW'($urandom));
         else if (r < 93) do_op(2'b10, a, '0);
         else             do_op(2'b11, a, DW'($urandom));
      end

      summary();
      $finish;
   end
endmodule